// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Selectable Byte Order

This block is a small synchronous data store. Storage is organised as 32-bit words, but every request names a byte address: consecutive addresses select consecutive bytes, and each word starts at an address that is a multiple of four. A request is either a word access or a single-byte access, and it is either a load or a store. One input selects how bytes map onto a word. When it is high, the byte at the lowest address of a word is the most significant byte. When it is low, that byte is the least significant byte.

Requests arrive on a valid/ready channel. Every accepted request produces exactly one response on a second valid/ready channel, one cycle later. The response carries the read data and an error flag. The request side is ready whenever no response is waiting, or when the waiting response is consumed in the same cycle. While a response is held by back-pressure, the request channel stalls and the response does not change. A word access whose address is not a multiple of four is refused: the block flags an error and does not write. Bits in a word are numbered 31 (most significant) down to 0.

Top module: `byteaddr_mem`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and right after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: An accepted request gives `rsp_valid` = 1 in the next cycle. A word load returns the 32-bit value last stored by a word store at that address.
- R3: With `big_endian` = 1, a byte load at word offset o (address bits [1:0]) returns word bits [31-8o:24-8o].
- R4: With `big_endian` = 0, a byte load at word offset o returns word bits [8o+7:8o].
- R5: A byte load returns the byte in `rsp_rdata[7:0]`, and `rsp_rdata[31:8]` is zero.
- R6: A byte store writes `req_wdata[7:0]` into the one lane chosen by the R3/R4 mapping. The other three bytes of that word keep their values.
- R7: A word access (`req_word` = 1) with address bits [1:0] not equal to 0 gives `rsp_err` = 1 and `rsp_rdata` = 0, and it leaves memory unchanged. Byte accesses and aligned word accesses give `rsp_err` = 0.
- R8: A load leaves memory unchanged, so repeating it returns the same data.
- R9: While `rsp_valid` = 1 and `rsp_ready` = 0, `req_ready` is 0 and the response holds its data and error flag.
- R10: A store's response has `rsp_rdata` = 0.
- R11: Word accesses do not depend on `big_endian`. A word stored under one byte order reads back unchanged under the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = 32-bit word access, 0 = single byte |
| req_wdata | input | 32 | Store data; a byte store uses bits [7:0] |
| big_endian | input | 1 | Byte order select: 1 = lowest address is most significant |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 32 | Load data, right-justified for byte loads |
| rsp_err | output | 1 | Misaligned word access |

## Verification
The checker watches every cycle for these properties: response latency after acceptance, holding the response under back-pressure, the request stall while a response waits, zeroed upper bits on byte loads, and the error behaviour for misaligned and byte accesses. Some behaviours need values carried from one access to a later one, and only the bench scenarios can show them. These are the lane chosen under each byte order, the untouched neighbours after a byte store, the write suppressed on a misaligned store, and word data that does not depend on the byte-order setting.

// File: rtl/byteaddr_mem_pkg.sv
package byteaddr_mem_pkg;
  localparam int unsigned LANE_W     = 8;
  localparam int unsigned WORD_LANES = 4;
  localparam int unsigned DATA_W     = LANE_W * WORD_LANES;
  localparam int unsigned OFS_W      = $clog2(WORD_LANES);

  typedef logic [OFS_W-1:0]      lane_idx_t;
  typedef logic [WORD_LANES-1:0] lane_mask_t;
  typedef logic [DATA_W-1:0]     word_t;
endpackage

// File: rtl/byteaddr_lane_steer.sv
module byteaddr_lane_steer
  import byteaddr_mem_pkg::*;
(
  input  lane_idx_t  offset,
  input  logic       is_word,
  input  logic       big_endian,
  input  word_t      wdata_in,
  output lane_idx_t  lane,
  output lane_mask_t lane_mask,
  output word_t      wdata_lanes
);
  // big-endian: lowest address holds the top lane
  assign lane = big_endian ? lane_idx_t'(WORD_LANES - 1) - offset : offset;

  always_comb begin
    lane_mask   = '0;
    wdata_lanes = wdata_in;
    if (is_word) begin
      lane_mask = '1;
    end else begin
      lane_mask[lane] = 1'b1;
      for (int k = 0; k < WORD_LANES; k++) begin
        wdata_lanes[k*LANE_W +: LANE_W] = wdata_in[LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/byteaddr_bank_array.sv
module byteaddr_bank_array
  import byteaddr_mem_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] idx,
  input  lane_mask_t       lane_we,
  input  word_t            wdata,
  output word_t            rdata
);
  for (genvar k = 0; k < WORD_LANES; k++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[k]) bank[idx] <= wdata[k*LANE_W +: LANE_W];
    end
    assign rdata[k*LANE_W +: LANE_W] = bank[idx];
  end
endmodule

// File: rtl/byteaddr_load_align.sv
module byteaddr_load_align
  import byteaddr_mem_pkg::*;
(
  input  word_t     raw,
  input  logic      is_word,
  input  lane_idx_t lane,
  output word_t     aligned
);
  always_comb begin
    if (is_word) aligned = raw;
    else         aligned = word_t'(raw[lane*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/byteaddr_mem.sv
module byteaddr_mem
  import byteaddr_mem_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [31:0]       req_wdata,
  input  logic              big_endian,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);
  localparam int unsigned DEPTH = 2 ** (ADDR_W - OFS_W);
  localparam int unsigned IDX_W = ADDR_W - OFS_W;

  lane_idx_t        offset, lane;
  lane_mask_t       lane_mask, lane_we;
  word_t            wdata_lanes, raw_word, load_word;
  logic [IDX_W-1:0] widx;
  logic             accept, misalign;

  assign offset    = req_addr[OFS_W-1:0];
  assign widx      = req_addr[ADDR_W-1:OFS_W];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign misalign  = req_word && (offset != '0);
  assign lane_we   = (accept && req_we && !misalign) ? lane_mask : '0;

  byteaddr_lane_steer u_steer (
    .offset      (offset),
    .is_word     (req_word),
    .big_endian  (big_endian),
    .wdata_in    (req_wdata),
    .lane        (lane),
    .lane_mask   (lane_mask),
    .wdata_lanes (wdata_lanes)
  );

  byteaddr_bank_array #(.DEPTH(DEPTH)) u_banks (
    .clk     (clk),
    .idx     (widx),
    .lane_we (lane_we),
    .wdata   (wdata_lanes),
    .rdata   (raw_word)
  );

  byteaddr_load_align u_align (
    .raw     (raw_word),
    .is_word (req_word),
    .lane    (lane),
    .aligned (load_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_err   <= misalign;
      rsp_rdata <= (!req_we && !misalign) ? load_word : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/byteaddr_mem_chk.sv
module byteaddr_mem_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_we,
  input logic              req_word,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_word && !req_we) |=> (rsp_rdata[31:8] == 24'h0));

  assert_misalign_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && (req_addr[1:0] != 2'b00)) |=> (rsp_err && rsp_rdata == 32'h0));

  assert_byte_no_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_word) |=> !rsp_err);

  assert_store_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_we) |=> (rsp_rdata == 32'h0));
endmodule

bind byteaddr_mem byteaddr_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_we    (req_we),
  .req_word  (req_word),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err)
);

// File: tb/tb_byteaddr_mem.sv
module tb_byteaddr_mem;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic        req_we = 1'b0;
  logic        req_word = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        big_endian = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int checks = 0;
  int fails  = 0;
  logic [31:0] got_d;
  logic        got_e;

  always #4 clk = ~clk;

  byteaddr_mem #(.ADDR_W(8)) dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request, response sampled at the negedge after acceptance
  task automatic xfer(input logic [7:0] a, input logic we, input logic wd,
                      input logic be, input logic [31:0] d);
    @(negedge clk);
    req_addr = a; req_we = we; req_word = wd; big_endian = be; req_wdata = d;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    got_d = rsp_rdata;
    got_e = rsp_err;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R1 req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_word;
    xfer(8'h10, 1, 1, 1, 32'hA1B2_C3D4);
    check("R10 store rdata", got_d, 32'h0);
    check("R7 aligned store err", 32'(got_e), 32'd0);
    xfer(8'h10, 0, 1, 1, 32'h0);
    check("R2 word load", got_d, 32'hA1B2_C3D4);
    xfer(8'h10, 0, 1, 0, 32'h0);
    check("R11 word load other order", got_d, 32'hA1B2_C3D4);
    xfer(8'h20, 1, 1, 0, 32'h0102_0304);
    xfer(8'h20, 0, 1, 1, 32'h0);
    check("R11 word LE store BE load", got_d, 32'h0102_0304);
  endtask

  task automatic t_byte_loads;
    logic [7:0] be_exp [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    for (int o = 0; o < 4; o++) begin
      xfer(8'h10 + 8'(o), 0, 0, 1, 32'hFFFF_FFFF);
      check("R3 R5 big-endian byte load", got_d, {24'h0, be_exp[o]});
      check("R7 byte no err", 32'(got_e), 32'd0);
    end
    for (int o = 0; o < 4; o++) begin
      xfer(8'h10 + 8'(o), 0, 0, 0, 32'h0);
      check("R4 R5 little-endian byte load", got_d, {24'h0, be_exp[3-o]});
    end
  endtask

  task automatic t_byte_store;
    xfer(8'h11, 1, 0, 1, 32'hFFFF_FF5E);
    check("R10 byte store rdata", got_d, 32'h0);
    xfer(8'h10, 0, 1, 0, 32'h0);
    check("R6 big-endian byte store", got_d, 32'hA15E_C3D4);
    xfer(8'h11, 1, 0, 0, 32'h0000_0077);
    xfer(8'h10, 0, 1, 0, 32'h0);
    check("R6 little-endian byte store", got_d, 32'hA15E_77D4);
  endtask

  task automatic t_misalign;
    xfer(8'h12, 1, 1, 0, 32'hFFFF_FFFF);
    check("R7 misaligned store err", 32'(got_e), 32'd1);
    xfer(8'h13, 0, 1, 1, 32'h0);
    check("R7 misaligned load err", 32'(got_e), 32'd1);
    check("R7 misaligned load rdata", got_d, 32'h0);
    xfer(8'h10, 0, 1, 0, 32'h0);
    check("R7 no write on misaligned store", got_d, 32'hA15E_77D4);
    check("R7 aligned load err", 32'(got_e), 32'd0);
  endtask

  task automatic t_load_repeat;
    xfer(8'h13, 0, 0, 1, 32'h0);
    check("R8 first byte load", got_d, 32'h0000_00D4);
    xfer(8'h13, 0, 0, 1, 32'h0);
    check("R8 repeated byte load", got_d, 32'h0000_00D4);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 8'h10; req_we = 0; req_word = 1; big_endian = 0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_addr = 8'h20;
    check("R9 stall ready", 32'(req_ready), 32'd0);
    check("R9 first data", rsp_rdata, 32'hA15E_77D4);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9 held valid", 32'(rsp_valid), 32'd1);
    check("R9 held data", rsp_rdata, 32'hA15E_77D4);
    rsp_ready = 1'b1;
    #1;
    check("R9 ready on consume", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 next response", rsp_rdata, 32'h0102_0304);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_word();
    t_byte_loads();
    t_byte_store();
    t_misalign();
    t_load_repeat();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule